// File: doc/BRIEF.md
# Spectral Subtraction Gain Unit

This unit sits between a forward transform and an inverse transform in a single-microphone noise suppressor. It takes a noisy spectrum one bin at a time, together with the noise power that an estimator has stored for that bin. For each bin it works out how strongly speech stands out above the noise and turns that into a real attenuation gain. It then scales both the real and the imaginary part of the bin by the gain, so the phase of the bin is left unchanged. Bins where noise dominates are pulled down. Bins that are well above the noise pass almost untouched.

The gain follows a clamped spectral-subtraction rule with two correction factors that software programs: a strength factor α and a shape exponent β. The unit never forms the signal-to-noise ratio itself. It computes the bounded reciprocal 1/max(1, P/N) with an iterative divider, where P is the bin power and N is the noise power. That value equals one over the clamped a priori SNR plus one. For β = 1 the unit takes an iterative square root of it. For β = 2 it uses the value as it is. Only one bin is in flight at a time. Both stream ports use valid/ready handshakes and carry the bin index with the data. A frame is 64 bins, and a new set of correction factors takes effect only at the start of a frame.

Top module: `ssg_gain_unit`

## Requirements
- R1: With bin power P = re² + im² and effective noise N, the ratio term r, in units of 1/65536, is 65536 when P ≤ N and floor(N·65536 / P) otherwise.
- R2: When the shape select is set (β = 2), the attenuation term is a = floor(α·r / 65536), where α is the unsigned Q1.15 strength value.
- R3: When the shape select is clear (β = 1), the attenuation term is a = floor(α·floor(√(r·65536)) / 65536).
- R4: The gain is G = 32768 − a in Q1.15, floored at 0. Each output component is floor(x·G / 32768), saturated to signed 16 bits. An output component never exceeds its input in magnitude and never takes the opposite sign.
- R5: A noise power of zero is handled as a noise power of one.
- R6: Each result carries the bin index of the input it was computed from.
- R7: A write with cfg_addr = 0 stages α from cfg_wdata[15:0]. A write with cfg_addr = 1 stages the shape select from cfg_wdata[0], where 1 means β = 2. Staged values become active only when a bin with index 0 is accepted, and they are used from that bin onward. Bins accepted before that keep the previous values.
- R8: After reset, out_valid is low, in_ready is high, and the active and staged values are α = 0x4000 (0.5) and β = 1.
- R9: in_ready stays low from the acceptance of a bin until its result is taken. While out_valid is high and out_ready is low, out_re, out_im and out_bin hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 1 | 0 selects α, 1 selects the shape select |
| cfg_wdata | input | 16 | Write data |
| in_valid | input | 1 | Input bin valid |
| in_ready | output | 1 | Unit can accept a bin |
| in_bin | input | 6 | Bin index within the frame |
| in_re | input | 16 | Real part, signed |
| in_im | input | 16 | Imaginary part, signed |
| in_noise | input | 32 | Estimated noise power of this bin, unsigned |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_bin | output | 6 | Bin index of the result |
| out_re | output | 16 | Scaled real part, signed |
| out_im | output | 16 | Scaled imaginary part, signed |

## Verification
Most internal faults show up on the very next result. A wrong remainder or quotient step in the divider, a wrong trial bit in the root, or a wrong gain subtraction each change out_re and out_im of the bin being processed, as soon as out_valid rises. Faults in coefficient staging are slower to appear. They show at the first bin 0 after a write, or on the bins between a mid-frame write and the next frame, so the stimulus writes coefficients in the middle of frames and compares bins on both sides of the frame boundary. Handshake faults show as a second bin being accepted while a result is still waiting, or as result data changing under back-pressure.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam int COEF_W     = 16;          // Q1.15 strength factor
  localparam int RATIO_FRAC = 16;          // ratio term: 1.0 == 2**RATIO_FRAC
  localparam int RATIO_W    = RATIO_FRAC + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_ROOT,
    ST_HOLD
  } ssg_state_e;
endpackage

// File: rtl/ssg_rst_sync.sv
module ssg_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ssg_cfg.sv
module ssg_cfg #(
  parameter int COEF_W = 16,
  parameter logic [COEF_W-1:0] ALPHA_RST = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              frame_start,
  output logic [COEF_W-1:0] alpha,
  output logic              beta2
);
  logic [COEF_W-1:0] alpha_stg_q;
  logic              beta2_stg_q;
  logic [COEF_W-1:0] alpha_act_q;
  logic              beta2_act_q;
  logic              wr_alpha, wr_beta;

  assign wr_alpha = wr_en && !wr_addr;
  assign wr_beta  = wr_en &&  wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alpha_stg_q <= ALPHA_RST;
      beta2_stg_q <= 1'b0;
      alpha_act_q <= ALPHA_RST;
      beta2_act_q <= 1'b0;
    end else begin
      if (wr_alpha)    alpha_stg_q <= wr_data;
      if (wr_beta)     beta2_stg_q <= wr_data[0];
      if (frame_start) begin
        alpha_act_q <= alpha_stg_q;
        beta2_act_q <= beta2_stg_q;
      end
    end
  end

  assign alpha = alpha_act_q;
  assign beta2 = beta2_act_q;
endmodule

// File: rtl/ssg_ratio.sv
module ssg_ratio #(
  parameter int PWR_W   = 32,
  parameter int NOISE_W = 32,
  parameter int Q_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PWR_W-1:0]   power,
  input  logic [NOISE_W-1:0] noise,
  output logic               done,
  output logic [Q_W:0]       ratio
);
  localparam int REM_W = PWR_W + 1;
  localparam int CMP_W = (PWR_W > NOISE_W) ? PWR_W : NOISE_W;
  localparam int CNT_W = $clog2(Q_W);

  logic [REM_W-1:0]   rem_q, rem_d;
  logic [PWR_W-1:0]   den_q;
  logic [Q_W-1:0]     quo_q, quo_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_q, busy_d;
  logic               done_q, done_d;
  logic               sat_q;
  logic [NOISE_W-1:0] noise_eff;
  logic [REM_W-1:0]   trial;
  logic               fits;
  logic               sat_now;

  assign noise_eff = (noise == '0) ? NOISE_W'(1) : noise;
  assign sat_now   = CMP_W'(power) <= CMP_W'(noise_eff);
  assign trial     = {rem_q[REM_W-2:0], 1'b0};
  assign fits      = trial >= {1'b0, den_q};

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      rem_d  = REM_W'(noise_eff);
      quo_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = fits ? (trial - {1'b0, den_q}) : trial;
      quo_d = {quo_q[Q_W-2:0], fits};
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(Q_W - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sat_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      if (start) begin
        den_q <= power;
        sat_q <= sat_now;
      end
    end
  end

  assign done  = done_q;
  assign ratio = sat_q ? {1'b1, {Q_W{1'b0}}} : {1'b0, quo_q};
endmodule

// File: rtl/ssg_root.sv
module ssg_root #(
  parameter int IN_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IN_W-1:0] value,
  output logic            done,
  output logic [IN_W-1:0] root
);
  localparam int RAD_W = 2 * IN_W - 1;
  localparam int SQ_W  = 2 * IN_W;

  logic [RAD_W-1:0] rad_q;
  logic [IN_W-1:0]  root_q, root_d;
  logic [IN_W-1:0]  mask_q, mask_d;
  logic             done_q, done_d;
  logic [IN_W-1:0]  trial;
  logic [SQ_W-1:0]  trial_sq;

  assign trial    = root_q | mask_q;
  assign trial_sq = SQ_W'(trial) * SQ_W'(trial);

  always_comb begin
    root_d = root_q;
    mask_d = mask_q;
    done_d = 1'b0;
    if (start) begin
      root_d = '0;
      mask_d = {1'b1, {(IN_W-1){1'b0}}};
    end else if (mask_q != '0) begin
      if (trial_sq <= {1'b0, rad_q}) root_d = trial;
      mask_d = mask_q >> 1;
      done_d = mask_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q  <= '0;
      root_q <= '0;
      mask_q <= '0;
      done_q <= 1'b0;
    end else begin
      root_q <= root_d;
      mask_q <= mask_d;
      done_q <= done_d;
      if (start) rad_q <= {value, {(IN_W-1){1'b0}}};
    end
  end

  assign done = done_q;
  assign root = root_q;
endmodule

// File: rtl/ssg_apply.sv
module ssg_apply #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int SHAPE_W = 17
) (
  input  logic        [COEF_W-1:0]  alpha,
  input  logic        [SHAPE_W-1:0] shape,
  input  logic signed [DATA_W-1:0]  x_re,
  input  logic signed [DATA_W-1:0]  x_im,
  output logic signed [DATA_W-1:0]  y_re,
  output logic signed [DATA_W-1:0]  y_im
);
  localparam int AW = COEF_W + SHAPE_W;
  localparam int PW = DATA_W + COEF_W + 1;
  localparam logic [COEF_W-1:0] UNITY = {1'b1, {(COEF_W-1){1'b0}}};
  localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic [AW-1:0]     atten_prod;
  logic [AW-1:0]     atten;
  logic [COEF_W-1:0] gain;

  assign atten_prod = AW'(alpha) * AW'(shape);
  assign atten      = atten_prod >> (SHAPE_W - 1);
  assign gain       = (atten >= AW'(UNITY)) ? '0 : (UNITY - atten[COEF_W-1:0]);

  logic signed [DATA_W-1:0] x_l [2];
  logic signed [DATA_W-1:0] y_l [2];

  assign x_l[0] = x_re;
  assign x_l[1] = x_im;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] ge;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    assign xe     = PW'(x_l[g]);
    assign ge     = $signed(PW'({1'b0, gain}));
    assign prod   = xe * ge;
    assign scaled = prod >>> (COEF_W - 1);

    always_comb begin
      if (scaled > MAXV)      y_l[g] = MAXV[DATA_W-1:0];
      else if (scaled < MINV) y_l[g] = MINV[DATA_W-1:0];
      else                    y_l[g] = scaled[DATA_W-1:0];
    end
  end

  assign y_re = y_l[0];
  assign y_im = y_l[1];
endmodule

// File: rtl/ssg_gain_unit.sv
module ssg_gain_unit
  import ssg_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NOISE_W    = 32,
  parameter int FRAME_BINS = 64,
  localparam int BIN_W     = $clog2(FRAME_BINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_addr,
  input  logic [COEF_W-1:0]        cfg_wdata,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [BIN_W-1:0]         in_bin,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  input  logic [NOISE_W-1:0]       in_noise,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [BIN_W-1:0]         out_bin,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);
  localparam int PWR_W = 2 * DATA_W;

  logic                     rst_n_s;
  ssg_state_e               state_q, state_d;
  logic signed [DATA_W-1:0] re_q, im_q;
  logic [BIN_W-1:0]         bin_q;
  logic signed [DATA_W-1:0] ore_q, oim_q;
  logic                     accept, load_out, root_start;
  logic                     div_done, root_done;
  logic [RATIO_W-1:0]       ratio, root, shape;
  logic [COEF_W-1:0]        alpha_act;
  logic                     beta2_act;
  logic signed [DATA_W-1:0] y_re, y_im;
  logic signed [PWR_W-1:0]  re_e, im_e, sq_re, sq_im;
  logic [PWR_W-1:0]         power;

  ssg_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign accept    = in_valid && in_ready;

  assign re_e  = PWR_W'(in_re);
  assign im_e  = PWR_W'(in_im);
  assign sq_re = re_e * re_e;
  assign sq_im = im_e * im_e;
  assign power = $unsigned(sq_re) + $unsigned(sq_im);

  ssg_cfg #(.COEF_W(COEF_W)) i_cfg (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en       (cfg_we),
    .wr_addr     (cfg_addr),
    .wr_data     (cfg_wdata),
    .frame_start (accept && (in_bin == '0)),
    .alpha       (alpha_act),
    .beta2       (beta2_act)
  );

  ssg_ratio #(.PWR_W(PWR_W), .NOISE_W(NOISE_W), .Q_W(RATIO_FRAC)) i_ratio (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (accept),
    .power (power),
    .noise (in_noise),
    .done  (div_done),
    .ratio (ratio)
  );

  ssg_root #(.IN_W(RATIO_W)) i_root (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (root_start),
    .value (ratio),
    .done  (root_done),
    .root  (root)
  );

  assign shape = beta2_act ? ratio : root;

  ssg_apply #(.DATA_W(DATA_W), .COEF_W(COEF_W), .SHAPE_W(RATIO_W)) i_apply (
    .alpha (alpha_act),
    .shape (shape),
    .x_re  (re_q),
    .x_im  (im_q),
    .y_re  (y_re),
    .y_im  (y_im)
  );

  always_comb begin
    state_d    = state_q;
    load_out   = 1'b0;
    root_start = 1'b0;
    case (state_q)
      ST_IDLE: if (in_valid) state_d = ST_DIV;
      ST_DIV: begin
        if (div_done) begin
          if (beta2_act) begin
            load_out = 1'b1;
            state_d  = ST_HOLD;
          end else begin
            root_start = 1'b1;
            state_d    = ST_ROOT;
          end
        end
      end
      ST_ROOT: begin
        if (root_done) begin
          load_out = 1'b1;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: if (out_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      re_q    <= '0;
      im_q    <= '0;
      bin_q   <= '0;
      ore_q   <= '0;
      oim_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        re_q  <= in_re;
        im_q  <= in_im;
        bin_q <= in_bin;
      end
      if (load_out) begin
        ore_q <= y_re;
        oim_q <= y_im;
      end
    end
  end

  assign out_bin = bin_q;
  assign out_re  = ore_q;
  assign out_im  = oim_q;
endmodule

// File: rtl/ssg_gain_unit_chk.sv
module ssg_gain_unit_chk #(
  parameter int DATA_W = 16,
  parameter int BIN_W  = 6,
  parameter int COEF_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [BIN_W-1:0]         in_bin,
  input logic signed [DATA_W-1:0] in_re,
  input logic signed [DATA_W-1:0] in_im,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [BIN_W-1:0]         out_bin,
  input logic signed [DATA_W-1:0] out_re,
  input logic signed [DATA_W-1:0] out_im,
  input logic [COEF_W-1:0]        alpha_act,
  input logic                     beta2_act
);
  logic signed [DATA_W-1:0] rec_re, rec_im;
  logic [BIN_W-1:0]         rec_bin;
  logic                     past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_re  <= '0;
      rec_im  <= '0;
      rec_bin <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (in_valid && in_ready) begin
        rec_re  <= in_re;
        rec_im  <= in_im;
        rec_bin <= in_bin;
      end
    end
  end

  function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] v);
    logic signed [DATA_W:0] e;
    e = (DATA_W+1)'(v);
    return (e < 0) ? $unsigned(-e) : $unsigned(e);
  endfunction

  function automatic logic no_growth(input logic signed [DATA_W-1:0] y,
                                     input logic signed [DATA_W-1:0] x);
    return (mag(y) <= mag(x)) && ((y == '0) || (y[DATA_W-1] == x[DATA_W-1]));
  endfunction

  a_r9_single_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r9_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_bin)));

  a_r6_bin_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bin == rec_bin));

  a_r4_no_growth_re: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> no_growth(out_re, rec_re));

  a_r4_no_growth_im: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> no_growth(out_im, rec_im));

  a_r7_frame_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(in_valid && in_ready && (in_bin == '0))) |->
      ($stable(alpha_act) && $stable(beta2_act)));
endmodule

bind ssg_gain_unit ssg_gain_unit_chk #(
  .DATA_W (DATA_W),
  .BIN_W  (BIN_W),
  .COEF_W (ssg_pkg::COEF_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_bin    (in_bin),
  .in_re     (in_re),
  .in_im     (in_im),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bin   (out_bin),
  .out_re    (out_re),
  .out_im    (out_im),
  .alpha_act (alpha_act),
  .beta2_act (beta2_act)
);

// File: tb/test_ssg_gain_unit.sv
`timescale 1ns/1ps
module test_ssg_gain_unit;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_we;
  logic               cfg_addr;
  logic [15:0]        cfg_wdata;
  logic               in_valid;
  logic               in_ready;
  logic [5:0]         in_bin;
  logic signed [15:0] in_re, in_im;
  logic [31:0]        in_noise;
  logic               out_valid;
  logic               out_ready;
  logic [5:0]         out_bin;
  logic signed [15:0] out_re, out_im;

  int n_checks = 0;
  int n_fail   = 0;
  int stg_a = 16384, act_a = 16384;
  bit stg_b2 = 0, act_b2 = 0;
  longint exp_re, exp_im;
  int exp_bin;

  always #5 clk = ~clk;

  ssg_gain_unit i_ssg_gain_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_bin(in_bin), .in_re(in_re), .in_im(in_im),
    .in_noise(in_noise), .out_valid(out_valid), .out_ready(out_ready), .out_bin(out_bin),
    .out_re(out_re), .out_im(out_im)
  );

  task automatic chk(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_ratio(longint p, longint n);
    longint ne = (n == 0) ? 1 : n;
    return (p <= ne) ? 65536 : (ne * 65536) / p;
  endfunction

  function automatic longint ref_isqrt(longint v);
    longint r = longint'($floor($sqrt(real'(v))));
    while (r * r > v) r--;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  function automatic longint ref_lane(longint x, longint alpha, bit b2, longint p, longint n);
    longint r = ref_ratio(p, n);
    longint s = b2 ? r : ref_isqrt(r * 65536);
    longint a = (alpha * s) >> 16;
    longint g = (a >= 32768) ? 0 : 32768 - a;
    longint y = (x * g) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  task automatic cfg_write(bit addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr) stg_b2 = data[0]; else stg_a = data & 16'hffff;
  endtask

  task automatic run_bin(string req, int bin, int re, int im, longint noise, int hold);
    longint p = longint'(re) * re + longint'(im) * im;
    int t = 0;
    if (bin == 0) begin act_a = stg_a; act_b2 = stg_b2; end
    exp_re  = ref_lane(re, act_a, act_b2, p, noise);
    exp_im  = ref_lane(im, act_a, act_b2, p, noise);
    exp_bin = bin;
    @(negedge clk);
    in_valid = 1'b1; in_bin = 6'(bin); in_re = 16'(re); in_im = 16'(im); in_noise = 32'(noise);
    while (!in_ready && t < 500) begin @(negedge clk); t++; end
    @(negedge clk);
    in_valid = 1'b0;
    t = 0;
    while (!out_valid && t < 500) begin @(negedge clk); t++; end
    if (!out_valid) begin chk({req, " R9 result timeout"}, 0, 1); return; end
    if (hold > 0) begin
      logic signed [15:0] hr = out_re, hi = out_im;
      repeat (hold) @(negedge clk);
      chk("R9 held result real", out_re, hr);
      chk("R9 held result imag", out_im, hi);
      chk("R9 busy while held", in_ready, 0);
    end
    chk({req, " real"}, out_re, exp_re);
    chk({req, " imag"}, out_im, exp_im);
    chk("R6 bin index", out_bin, exp_bin);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_init = $urandom(32'd2718);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    in_valid = 1'b0; in_bin = '0; in_re = '0; in_im = '0; in_noise = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", out_valid, 0);
    chk("R8 reset in_ready", in_ready, 1);

    // R8: reset coefficients (alpha 0.5, beta 1) on a noisy bin
    run_bin("R8 reset coefficients", 0, 3000, 4000, 6250000, 0);
    // R1: power below noise -> ratio term 1.0
    cfg_write(0, 16'h6000);
    cfg_write(1, 1);
    run_bin("R1 low SNR clamp", 0, 1000, -500, 10000000, 0);
    // R5: zero noise handled as one
    run_bin("R5 zero noise", 1, -20000, 0, 0, 0);
    // R7: mid-frame write must not touch the current frame; R2 beta 2 path
    cfg_write(0, 16'h7fff);
    cfg_write(1, 0);
    run_bin("R7 mid-frame write ignored (R2)", 2, 3000, 4000, 6250000, 0);
    // R7: new values from next bin 0; R3 beta 1 path; R9 back-pressure
    run_bin("R7 applied at bin 0 (R3)", 0, 3000, 4000, 6250000, 4);
    run_bin("R3 equal power and noise", 1, -32768, -32768, 64'd2147483648, 0);
    // R4: identity gain at alpha 0 and full-scale negative input
    cfg_write(0, 0);
    run_bin("R4 alpha zero before frame", 2, 1234, -4321, 99999999, 0);
    run_bin("R4 alpha zero full scale", 0, -32768, 32767, 1, 0);

    for (int f = 0; f < 4; f++) begin
      for (int b = 0; b < 64; b++) begin
        int sh = $urandom % 12;
        int re = int'($signed(16'($urandom))) >>> sh;
        int im = int'($signed(16'($urandom))) >>> sh;
        longint p = longint'(re) * re + longint'(im) * im;
        longint nz;
        case ($urandom % 4)
          0: nz = 0;
          1: nz = p >> ($urandom % 8);
          2: nz = p << ($urandom % 3);
          default: nz = longint'($urandom) >> ($urandom % 32);
        endcase
        if (nz > 64'hffffffff) nz = 64'hffffffff;
        if ($urandom % 16 == 0) cfg_write(0, ($urandom % 8 == 0) ? 16'h7fff : $urandom % 32768);
        if ($urandom % 20 == 0) cfg_write(1, $urandom % 2);
        run_bin(stg_b2 ? "R4 random (R2)" : "R4 random (R3)", b, re, im, nz,
                ($urandom % 10 == 0) ? 3 : 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule